// File: doc/BRIEF.md
# UART Channel Command and Mode-Pointer Unit

This block is the per-channel control slice of a dual UART. It holds the channel's two mode registers behind a single register address and decodes writes to the channel command register into strobes for the receiver, transmitter, status and interrupt logic. The serial engines, FIFOs and baud generation sit outside it.

The two mode registers share one address. An internal pointer chooses which one that address reaches. The pointer starts on the first mode register. Any read or write of the first register moves it to the second, where it stays until a pointer-reset command arrives.

A command byte carries two kinds of command at once. Its low nibble holds independent enable/disable requests for the receiver and the transmitter. Its high nibble holds one encoded miscellaneous command. The miscellaneous commands are: receiver reset, transmitter reset, error-status clear, break-change interrupt clear, break start and stop, timeout mode on and off, RTS assert and negate, and pointer reset. Every command effect is a one-cycle pulse, except the RTS output, which is a held level.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset the mode pointer selects mode register 1. A command write whose high nibble is 0001 returns the pointer to mode register 1.
- R2: A read or write at the mode address while the pointer selects mode register 1 moves the pointer to mode register 2. Accesses while it selects mode register 2 leave it there.
- R3: `rdata_o` shows the mode register that the pointer selects. A mode write updates only that register. Both registers reset to 0x00.
- R4: The low nibble of a command holds two enable/disable pairs: bits [1:0] for the receiver and bits [3:2] for the transmitter. In each pair, 01 pulses enable, 10 pulses disable, and 00 or 11 does nothing.
- R5: High-nibble code 0010 pulses `rx_rst_o`. Code 0011 pulses `tx_rst_o`.
- R6: Code 0100 pulses `err_clr_o`, which clears status bits 7 to 4 (break, framing, parity, overrun). Code 0101 pulses `brk_int_clr_o`, which clears interrupt status bit 2.
- R7: Code 0110 pulses `brk_start_o`. Code 0111 pulses `brk_stop_o`. Code 1010 pulses `tmo_on_o`. Code 1100 pulses `tmo_off_o`.
- R8: `rts_no` resets high. Code 1000 drives it low and code 1001 drives it high. It holds its value at all other times.
- R9: Codes 0000, 1011, 1101, 1110 and 1111 produce no pulse and leave `rts_no` unchanged.
- R10: If a command word carries a receiver reset (or transmitter reset), an enable for that same direction in the same word is suppressed. Disables and the other direction's requests still take effect.
- R11: Every pulse lasts exactly one cycle and appears in the cycle after the command write. With no command write, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 = mode address, 1 = command address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Mode register selected by the pointer |
| mode1_o | output | 8 | Mode register 1 contents |
| mode2_o | output | 8 | Mode register 2 contents |
| rx_en_o | output | 1 | Receiver enable pulse |
| rx_dis_o | output | 1 | Receiver disable pulse |
| tx_en_o | output | 1 | Transmitter enable pulse |
| tx_dis_o | output | 1 | Transmitter disable pulse |
| rx_rst_o | output | 1 | Receiver reset pulse (disable and flush FIFO) |
| tx_rst_o | output | 1 | Transmitter reset pulse |
| err_clr_o | output | 1 | Error-status clear pulse |
| brk_int_clr_o | output | 1 | Break-change interrupt clear pulse |
| brk_start_o | output | 1 | Break start request pulse |
| brk_stop_o | output | 1 | Break stop request pulse |
| tmo_on_o | output | 1 | Timeout mode on request pulse |
| tmo_off_o | output | 1 | Timeout mode off request pulse |
| rts_no | output | 1 | Active-low RTS level |

## Verification
The command decoder is driven from a table that covers every high-nibble code, every low-nibble pair value including the 11 no-action case, and words that combine both nibbles. Each row is checked against its full pulse vector. This exposes a decoder that mixes up adjacent codes, reacts to a reserved code, or drops one of two simultaneous requests. Words that pair a reset with an enable for the same direction separate the suppression rule from plain merging. In each case the cycle after the pulse is checked for silence. Directed sequences then walk the mode pointer through writes, reads and pointer resets. Because mode register contents are read back through the shared address, a pointer that advances from mode register 2, or fails to advance on a read, shows up as wrong data.

// File: rtl/uart_cc_pkg.sv
package uart_cc_pkg;

  typedef enum logic [3:0] {
    MISC_NOP         = 4'h0,
    MISC_PTR_RST     = 4'h1,
    MISC_RX_RST      = 4'h2,
    MISC_TX_RST      = 4'h3,
    MISC_ERR_CLR     = 4'h4,
    MISC_BRK_INT_CLR = 4'h5,
    MISC_BRK_START   = 4'h6,
    MISC_BRK_STOP    = 4'h7,
    MISC_RTS_ASSERT  = 4'h8,
    MISC_RTS_NEGATE  = 4'h9,
    MISC_TMO_ON      = 4'hA,
    MISC_RSVD_B      = 4'hB,
    MISC_TMO_OFF     = 4'hC,
    MISC_RSVD_D      = 4'hD,
    MISC_RSVD_E      = 4'hE,
    MISC_RSVD_F      = 4'hF
  } misc_cmd_e;

  typedef enum logic [1:0] {
    PAIR_NOP  = 2'b00,
    PAIR_ON   = 2'b01,
    PAIR_OFF  = 2'b10,
    PAIR_BOTH = 2'b11
  } en_pair_e;

  typedef enum logic {
    PTR_MR1 = 1'b0,
    PTR_MR2 = 1'b1
  } mr_ptr_e;

  typedef struct packed {
    logic rx_en;
    logic rx_dis;
    logic tx_en;
    logic tx_dis;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brk_int_clr;
    logic brk_start;
    logic brk_stop;
    logic tmo_on;
    logic tmo_off;
  } cmd_pulse_t;

  localparam int unsigned CMD_W   = 8;
  localparam int unsigned PAIR_N  = 2;  // 0 = receiver, 1 = transmitter

endpackage

// File: rtl/uart_cc_mode_regs.sv
module uart_cc_mode_regs
  import uart_cc_pkg::*;
#(
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] wdata_i,
  input  logic              ptr_rst_i,
  output logic [MODE_W-1:0] mr1_o,
  output logic [MODE_W-1:0] mr2_o,
  output logic [MODE_W-1:0] rdata_o
);

  mr_ptr_e           ptr_q;
  logic [MODE_W-1:0] mr1_q, mr2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= PTR_MR1;
    end else if (ptr_rst_i) begin
      ptr_q <= PTR_MR1;
    end else if (acc_i) begin
      ptr_q <= PTR_MR2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mr1_q <= '0;
      mr2_q <= '0;
    end else if (acc_i && wr_i) begin
      if (ptr_q == PTR_MR1) mr1_q <= wdata_i;
      else                  mr2_q <= wdata_i;
    end
  end

  assign mr1_o   = mr1_q;
  assign mr2_o   = mr2_q;
  assign rdata_o = (ptr_q == PTR_MR2) ? mr2_q : mr1_q;

  // R2
  ptr_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !ptr_rst_i) |=> (ptr_q == PTR_MR2));

  // R1
  ptr_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_rst_i |=> (ptr_q == PTR_MR1));

  // R3
  mr1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_q == PTR_MR2) |=> $stable(mr1_q));

endmodule

// File: rtl/uart_cc_cmd_dec.sv
module uart_cc_cmd_dec
  import uart_cc_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_pulse_t       pulse_o,
  output logic             ptr_rst_o,
  output logic             rts_assert_o,
  output logic             rts_negate_o
);

  misc_cmd_e           misc;
  logic [PAIR_N-1:0]   en_req, dis_req, rst_req;

  assign misc = misc_cmd_e'(cmd_i[CMD_W-1 -: 4]);

  assign rst_req[0] = (misc == MISC_RX_RST);
  assign rst_req[1] = (misc == MISC_TX_RST);

  for (genvar g = 0; g < PAIR_N; g++) begin : g_pair
    en_pair_e pair;
    assign pair       = en_pair_e'(cmd_i[2*g +: 2]);
    // a reset in the same word wins over an enable of that direction
    assign en_req[g]  = (pair == PAIR_ON) && !rst_req[g];
    assign dis_req[g] = (pair == PAIR_OFF);
  end

  always_comb begin
    pulse_o             = '0;
    pulse_o.rx_en       = en_req[0];
    pulse_o.rx_dis      = dis_req[0];
    pulse_o.tx_en       = en_req[1];
    pulse_o.tx_dis      = dis_req[1];
    pulse_o.rx_rst      = rst_req[0];
    pulse_o.tx_rst      = rst_req[1];
    pulse_o.err_clr     = (misc == MISC_ERR_CLR);
    pulse_o.brk_int_clr = (misc == MISC_BRK_INT_CLR);
    pulse_o.brk_start   = (misc == MISC_BRK_START);
    pulse_o.brk_stop    = (misc == MISC_BRK_STOP);
    pulse_o.tmo_on      = (misc == MISC_TMO_ON);
    pulse_o.tmo_off     = (misc == MISC_TMO_OFF);
  end

  assign ptr_rst_o    = (misc == MISC_PTR_RST);
  assign rts_assert_o = (misc == MISC_RTS_ASSERT);
  assign rts_negate_o = (misc == MISC_RTS_NEGATE);

  always_comb begin
    // R10
    rx_conflict_chk: assert (!(pulse_o.rx_en && pulse_o.rx_rst));
    // R10
    tx_conflict_chk: assert (!(pulse_o.tx_en && pulse_o.tx_rst));
    // R9
    misc_onehot_chk: assert ($onehot0({pulse_o.rx_rst, pulse_o.tx_rst, pulse_o.err_clr,
                                       pulse_o.brk_int_clr, pulse_o.brk_start, pulse_o.brk_stop,
                                       pulse_o.tmo_on, pulse_o.tmo_off, ptr_rst_o,
                                       rts_assert_o, rts_negate_o}));
  end

endmodule

// File: rtl/uart_cc_cmd_reg.sv
module uart_cc_cmd_reg
  import uart_cc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_cmd_i,
  input  cmd_pulse_t pulse_i,
  input  logic       rts_assert_i,
  input  logic       rts_negate_i,
  output cmd_pulse_t pulse_o,
  output logic       rts_no
);

  cmd_pulse_t pulse_q;
  logic       rts_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= wr_cmd_i ? pulse_i : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_nq <= 1'b1;
    end else if (wr_cmd_i && rts_assert_i) begin
      rts_nq <= 1'b0;
    end else if (wr_cmd_i && rts_negate_i) begin
      rts_nq <= 1'b1;
    end
  end

  assign pulse_o = pulse_q;
  assign rts_no  = rts_nq;

  // R11
  no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cmd_i |=> (pulse_q == '0));

  // R11
  single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q != '0 && !wr_cmd_i) |=> (pulse_q == '0));

  // R8
  rts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_cmd_i && (rts_assert_i || rts_negate_i)) |=> $stable(rts_nq));

  // R8
  rts_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd_i && rts_assert_i) |=> !rts_nq);

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import uart_cc_pkg::*;
#(
  parameter int unsigned MODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic              addr_i,
  input  logic [MODE_W-1:0] wdata_i,
  output logic [MODE_W-1:0] rdata_o,
  output logic [MODE_W-1:0] mode1_o,
  output logic [MODE_W-1:0] mode2_o,
  output logic              rx_en_o,
  output logic              rx_dis_o,
  output logic              tx_en_o,
  output logic              tx_dis_o,
  output logic              rx_rst_o,
  output logic              tx_rst_o,
  output logic              err_clr_o,
  output logic              brk_int_clr_o,
  output logic              brk_start_o,
  output logic              brk_stop_o,
  output logic              tmo_on_o,
  output logic              tmo_off_o,
  output logic              rts_no
);

  localparam logic ADDR_MODE = 1'b0;
  localparam logic ADDR_CMD  = 1'b1;

  logic       mode_acc, mode_wr, cmd_wr;
  logic       ptr_rst, rts_assert, rts_negate;
  cmd_pulse_t dec_pulse, out_pulse;

  assign mode_acc = (wr_en_i || rd_en_i) && (addr_i == ADDR_MODE);
  assign mode_wr  = wr_en_i && (addr_i == ADDR_MODE);
  assign cmd_wr   = wr_en_i && (addr_i == ADDR_CMD);

  uart_cc_cmd_dec u_dec (
    .cmd_i        (wdata_i[CMD_W-1:0]),
    .pulse_o      (dec_pulse),
    .ptr_rst_o    (ptr_rst),
    .rts_assert_o (rts_assert),
    .rts_negate_o (rts_negate)
  );

  uart_cc_mode_regs #(.MODE_W(MODE_W)) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (mode_acc),
    .wr_i      (mode_wr),
    .wdata_i   (wdata_i),
    .ptr_rst_i (cmd_wr && ptr_rst),
    .mr1_o     (mode1_o),
    .mr2_o     (mode2_o),
    .rdata_o   (rdata_o)
  );

  uart_cc_cmd_reg u_creg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_cmd_i     (cmd_wr),
    .pulse_i      (dec_pulse),
    .rts_assert_i (rts_assert),
    .rts_negate_i (rts_negate),
    .pulse_o      (out_pulse),
    .rts_no       (rts_no)
  );

  assign rx_en_o       = out_pulse.rx_en;
  assign rx_dis_o      = out_pulse.rx_dis;
  assign tx_en_o       = out_pulse.tx_en;
  assign tx_dis_o      = out_pulse.tx_dis;
  assign rx_rst_o      = out_pulse.rx_rst;
  assign tx_rst_o      = out_pulse.tx_rst;
  assign err_clr_o     = out_pulse.err_clr;
  assign brk_int_clr_o = out_pulse.brk_int_clr;
  assign brk_start_o   = out_pulse.brk_start;
  assign brk_stop_o    = out_pulse.brk_stop;
  assign tmo_on_o      = out_pulse.tmo_on;
  assign tmo_off_o     = out_pulse.tmo_off;

  // R5
  rx_rst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |-> $past(cmd_wr && wdata_i[7:4] == 4'h2));

  // R6
  err_clr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_clr_o |-> $past(cmd_wr && wdata_i[7:4] == 4'h4));

endmodule

// File: tb/tb_uart_chan_ctrl.sv
module tb_uart_chan_ctrl;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0, addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, mode1_o, mode2_o;
  logic       rx_en_o, rx_dis_o, tx_en_o, tx_dis_o, rx_rst_o, tx_rst_o;
  logic       err_clr_o, brk_int_clr_o, brk_start_o, brk_stop_o, tmo_on_o, tmo_off_o, rts_no;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  uart_chan_ctrl dut (.*);

  logic [11:0] pulses;
  assign pulses = {rx_en_o, rx_dis_o, tx_en_o, tx_dis_o, rx_rst_o, tx_rst_o,
                   err_clr_o, brk_int_clr_o, brk_start_o, brk_stop_o, tmo_on_o, tmo_off_o};

  // {cmd[7:0], expected pulses[11:0], expected rts_no}
  localparam int NV = 28;
  localparam logic [20:0] VEC [NV] = '{
    {8'h01, 12'h800, 1'b1}, {8'h02, 12'h400, 1'b1}, {8'h03, 12'h000, 1'b1},
    {8'h04, 12'h200, 1'b1}, {8'h08, 12'h100, 1'b1}, {8'h0C, 12'h000, 1'b1},
    {8'h05, 12'hA00, 1'b1}, {8'h0A, 12'h500, 1'b1}, {8'h20, 12'h080, 1'b1},
    {8'h30, 12'h040, 1'b1}, {8'h40, 12'h020, 1'b1}, {8'h50, 12'h010, 1'b1},
    {8'h60, 12'h008, 1'b1}, {8'h70, 12'h004, 1'b1}, {8'h80, 12'h000, 1'b0},
    {8'h05, 12'hA00, 1'b0}, {8'hB0, 12'h000, 1'b0}, {8'h90, 12'h000, 1'b1},
    {8'hA0, 12'h002, 1'b1}, {8'hC0, 12'h001, 1'b1}, {8'hD0, 12'h000, 1'b1},
    {8'hE0, 12'h000, 1'b1}, {8'hF0, 12'h000, 1'b1}, {8'h00, 12'h000, 1'b1},
    {8'h21, 12'h080, 1'b1}, {8'h34, 12'h040, 1'b1}, {8'h25, 12'h280, 1'b1},
    {8'h36, 12'h440, 1'b1}
  };

  function automatic string req_of(input logic [7:0] c);
    case (c[7:4])
      4'h0:       return (c[3:0] == 4'h0) ? "R9" : "R4";
      4'h2, 4'h3: return (c[3:0] == 4'h0) ? "R5" : "R10";
      4'h4, 4'h5: return "R6";
      4'h6, 4'h7, 4'hA, 4'hC: return "R7";
      4'h8, 4'h9: return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, write lands at next posedge, sample at following negedge
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_mode(output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = 1'b0;
    d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 5000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // reset state
    chk("R8 rts reset", 32'(rts_no), 32'h1);
    chk("R11 no pulse at reset", 32'(pulses), 32'h0);
    chk("R3 mode1 reset", 32'(mode1_o), 32'h0);
    chk("R1 readback at reset", 32'(rdata_o), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(1'b1, VEC[i][20:13]);
      chk(req_of(VEC[i][20:13]), 32'(pulses), 32'(VEC[i][12:1]));
      chk("R8 rts level", 32'(rts_no), 32'(VEC[i][0]));
      @(negedge clk_i);
      chk("R11 pulse one cycle", 32'(pulses), 32'h0);
    end

    // pointer walk
    wr(1'b0, 8'hA5);
    chk("R3 write mr1", 32'(mode1_o), 32'hA5);
    chk("R2 advanced after mr1 write", 32'(rdata_o), 32'h00);
    wr(1'b0, 8'h3C);
    chk("R3 write mr2", 32'(mode2_o), 32'h3C);
    chk("R3 mr1 kept", 32'(mode1_o), 32'hA5);
    wr(1'b0, 8'h77);
    chk("R2 stays on mr2", 32'(mode2_o), 32'h77);
    chk("R2 mr1 untouched", 32'(mode1_o), 32'hA5);
    wr(1'b1, 8'h10);
    chk("R1 pointer reset no pulse", 32'(pulses), 32'h0);
    chk("R1 pointer at mr1", 32'(rdata_o), 32'hA5);
    rd_mode(rd);
    chk("R3 read mr1", 32'(rd), 32'hA5);
    rd_mode(rd);
    chk("R2 read advanced", 32'(rd), 32'h77);
    rd_mode(rd);
    chk("R2 read stays", 32'(rd), 32'h77);
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h5A);
    chk("R1 write after pointer reset", 32'(mode1_o), 32'h5A);
    chk("R1 mr2 unchanged", 32'(mode2_o), 32'h77);

    // back-to-back commands: pulse follows each write
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 1'b1; wdata_i = 8'h20;
    @(negedge clk_i);
    chk("R11 first of pair", 32'(pulses), 32'h080);
    wdata_i = 8'h30;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R11 second of pair", 32'(pulses), 32'h040);
    @(negedge clk_i);
    chk("R11 quiet after pair", 32'(pulses), 32'h0);

    // command data at mode address does nothing
    wr(1'b1, 8'h10);
    wr(1'b0, 8'h80);
    chk("R11 mode write no pulse", 32'(pulses), 32'h0);
    chk("R8 mode write no rts", 32'(rts_no), 32'h1);

    // async reset restores pointer and rts
    wr(1'b1, 8'h80);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 rts after reset", 32'(rts_no), 32'h1);
    chk("R3 mr1 after reset", 32'(mode1_o), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule